// File: doc/BRIEF.md
# Sequential Restoring Sign-Magnitude Divider

This block divides a double-width dividend by a single-width divisor, both given in sign-magnitude form, over several clock cycles. After a start pulse it captures the operand magnitudes into a working register pair (high half and low half) and a divisor register. It forms the quotient sign as the exclusive-or of the two operand signs. It then screens the operands for three early exits: a zero divisor, a quotient that cannot fit, and a trivially zero quotient. Each exit finishes the operation one cycle after the start.

When no exit applies, the block performs one restoring step per cycle. Each step shifts the register pair left by one bit and tries to subtract the divisor from the high half. It keeps the difference and records a quotient bit of 1, or discards the difference and records a 0. After the last step, an optional rounding stage adds one to the quotient magnitude when the remainder is at least half the divisor. The quotient is then given in two's-complement form according to its sign. The results stay registered until the next accepted start.

Top module: `div_restore_sm`

## Requirements
- R1: While and right after reset, busy_o, done_o, ovf_o, dz_o and zero_o are 0, and quo_o, quo_sign_o and rem_o are 0.
- R2: start_i is taken only when busy_o is 0. An accepted start makes busy_o 1 on the next cycle. busy_o stays 1 until the cycle in which done_o is 1, and it is 0 in that cycle. done_o is 1 for exactly one cycle. A start_i raised while busy_o is 1 has no effect on the results or on the timing.
- R3: With a nonzero divisor and a high dividend half (bits 2N-1..N of the magnitude) greater than or equal to the divisor, ovf_o is 1 and dz_o and zero_o are 0. quo_o and rem_o are 0, and done_o rises one clock edge after the start edge.
- R4: With a zero divisor, dz_o is 1 and ovf_o and zero_o are 0. quo_o and rem_o are 0, and done_o rises one clock edge after the start edge.
- R5: With a nonzero divisor, a zero high half, and a low half below the divisor, zero_o is 1 and quo_o is 0. rem_o equals the low half, and done_o rises one clock edge after the start edge.
- R6: In all other cases, done_o rises N+2 clock edges after the start edge. All three flags are 0, and rem_o equals the dividend magnitude modulo the divisor magnitude.
- R7: quo_sign_o equals the exclusive-or of the dividend and divisor sign bits for every completed operation, including early exits.
- R8: With ROUND_EN=1 and no early exit, the quotient magnitude is floor(dividend/divisor), plus one when twice the remainder is greater than or equal to the divisor. With ROUND_EN=0 it is the floor alone.
- R9: quo_o is N+2 bits wide. It equals the quotient magnitude when quo_sign_o is 0, and the two's-complement negation of that magnitude when quo_sign_o is 1.
- R10: After done_o, quo_o, quo_sign_o, rem_o and the flags hold their values until the next operation completes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start_i | input | 1 | Begin a division (taken only when idle) |
| dvd_sign_i | input | 1 | Dividend sign (1 = negative) |
| dvd_mag_i | input | 2N | Dividend magnitude |
| dvs_sign_i | input | 1 | Divisor sign (1 = negative) |
| dvs_mag_i | input | N | Divisor magnitude |
| busy_o | output | 1 | Operation in progress |
| done_o | output | 1 | One-cycle completion pulse |
| quo_o | output | N+2 | Signed quotient, two's complement |
| quo_sign_o | output | 1 | Quotient sign |
| rem_o | output | N | Remainder magnitude |
| ovf_o | output | 1 | Quotient does not fit |
| dz_o | output | 1 | Divisor was zero |
| zero_o | output | 1 | Trivially zero quotient |

## Verification
All results appear in the cycle when done_o rises. For an early exit, that is one clock edge after the edge that samples start_i. For a full division, it is N+2 edges after that edge: one screening edge, N step edges and one finishing edge. The bench counts falling edges from the start drive and compares that count with the latency it predicts from the operands. It reads the outputs at the falling edge where done_o is first seen high, then reads them again several cycles later to confirm they have held.

// File: rtl/div_restore_pkg.sv
package div_restore_pkg;
   typedef enum logic [1:0] {
      ST_IDLE  = 2'd0,
      ST_CHECK = 2'd1,
      ST_ITER  = 2'd2,
      ST_FIN   = 2'd3
   } div_state_t;
endpackage

// File: rtl/div_precheck.sv
module div_precheck #(
   parameter int N = 8
) (
   input  logic [N-1:0] hi_i,
   input  logic [N-1:0] lo_i,
   input  logic [N-1:0] dvs_i,
   output logic         dz_o,
   output logic         ovf_o,
   output logic         zro_o
);
   // Priority: zero divisor, then overflow, then trivially zero result
   always_comb begin
      dz_o  = (dvs_i == '0);
      ovf_o = !dz_o && (hi_i >= dvs_i);
      zro_o = !dz_o && !ovf_o && (hi_i == '0) && (lo_i < dvs_i);
   end
endmodule

// File: rtl/div_step.sv
module div_step #(
   parameter int N = 8
) (
   input  logic [N-1:0] hi_i,
   input  logic [N-1:0] lo_i,
   input  logic [N-1:0] dvs_i,
   output logic [N-1:0] hi_o,
   output logic [N-1:0] lo_o
);
   localparam int W = N + 1;
   logic [W-1:0] shifted;
   logic [W-1:0] trial;
   logic         qbit;

   always_comb begin
      shifted = {hi_i, lo_i[N-1]};
      trial   = shifted - {1'b0, dvs_i};
      qbit    = !trial[W-1];
      hi_o    = qbit ? trial[N-1:0] : shifted[N-1:0];
      lo_o    = {lo_i[N-2:0], qbit};
   end
endmodule

// File: rtl/div_finish.sv
module div_finish #(
   parameter int N        = 8,
   parameter bit ROUND_EN = 1'b1
) (
   input  logic [N-1:0] qmag_i,
   input  logic [N-1:0] rem_i,
   input  logic [N-1:0] dvs_i,
   input  logic         sign_i,
   output logic [N+1:0] quo_o
);
   localparam int QW = N + 2;
   logic          bump;
   logic [QW-1:0] mag;

   generate
      if (ROUND_EN) begin : g_round
         assign bump = ({rem_i, 1'b0} >= {1'b0, dvs_i});
      end else begin : g_trunc
         assign bump = 1'b0;
      end
   endgenerate

   always_comb begin
      mag   = {2'b00, qmag_i} + QW'(bump);
      quo_o = sign_i ? (~mag + QW'(1)) : mag;
   end
endmodule

// File: rtl/div_restore_sm.sv
module div_restore_sm
   import div_restore_pkg::*;
#(
   parameter int N        = 8,
   parameter bit ROUND_EN = 1'b1
) (
   input  logic           clk,
   input  logic           rst_n,
   input  logic           start_i,
   input  logic           dvd_sign_i,
   input  logic [2*N-1:0] dvd_mag_i,
   input  logic           dvs_sign_i,
   input  logic [N-1:0]   dvs_mag_i,
   output logic           busy_o,
   output logic           done_o,
   output logic [N+1:0]   quo_o,
   output logic           quo_sign_o,
   output logic [N-1:0]   rem_o,
   output logic           ovf_o,
   output logic           dz_o,
   output logic           zero_o
);
   localparam int CW = $clog2(N + 1);
   localparam int QW = N + 2;

   generate
      if (N < 2) begin : g_bad_n
         $error("div_restore_sm: N must be at least 2");
      end
   endgenerate

   div_state_t    state_r;
   logic [N-1:0]  hi_r, lo_r, dvs_r;
   logic          sgn_r;
   logic [CW-1:0] cnt_r;

   logic          pc_dz, pc_ovf, pc_zro;
   logic [N-1:0]  hi_nx, lo_nx;
   logic [QW-1:0] fin_quo;

   div_precheck #(.N(N)) u_precheck (
      .hi_i (hi_r), .lo_i (lo_r), .dvs_i (dvs_r),
      .dz_o (pc_dz), .ovf_o (pc_ovf), .zro_o (pc_zro)
   );

   div_step #(.N(N)) u_step (
      .hi_i (hi_r), .lo_i (lo_r), .dvs_i (dvs_r),
      .hi_o (hi_nx), .lo_o (lo_nx)
   );

   div_finish #(.N(N), .ROUND_EN(ROUND_EN)) u_finish (
      .qmag_i (lo_r), .rem_i (hi_r), .dvs_i (dvs_r),
      .sign_i (sgn_r), .quo_o (fin_quo)
   );

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         state_r    <= ST_IDLE;
         hi_r       <= '0;
         lo_r       <= '0;
         dvs_r      <= '0;
         sgn_r      <= 1'b0;
         cnt_r      <= '0;
         done_o     <= 1'b0;
         quo_o      <= '0;
         quo_sign_o <= 1'b0;
         rem_o      <= '0;
         ovf_o      <= 1'b0;
         dz_o       <= 1'b0;
         zero_o     <= 1'b0;
      end else begin
         done_o <= 1'b0;
         unique case (state_r)
            ST_IDLE: begin
               if (start_i) begin
                  hi_r    <= dvd_mag_i[2*N-1:N];
                  lo_r    <= dvd_mag_i[N-1:0];
                  dvs_r   <= dvs_mag_i;
                  sgn_r   <= dvd_sign_i ^ dvs_sign_i;
                  state_r <= ST_CHECK;
               end
            end
            ST_CHECK: begin
               if (pc_dz || pc_ovf || pc_zro) begin
                  quo_o      <= '0;
                  rem_o      <= pc_zro ? lo_r : '0;
                  quo_sign_o <= sgn_r;
                  ovf_o      <= pc_ovf;
                  dz_o       <= pc_dz;
                  zero_o     <= pc_zro;
                  done_o     <= 1'b1;
                  state_r    <= ST_IDLE;
               end else begin
                  cnt_r   <= '0;
                  state_r <= ST_ITER;
               end
            end
            ST_ITER: begin
               hi_r  <= hi_nx;
               lo_r  <= lo_nx;
               cnt_r <= cnt_r + CW'(1);
               if (cnt_r == CW'(N - 1)) state_r <= ST_FIN;
            end
            ST_FIN: begin
               quo_o      <= fin_quo;
               rem_o      <= hi_r;
               quo_sign_o <= sgn_r;
               ovf_o      <= 1'b0;
               dz_o       <= 1'b0;
               zero_o     <= 1'b0;
               done_o     <= 1'b1;
               state_r    <= ST_IDLE;
            end
            default: state_r <= ST_IDLE;
         endcase
      end
   end

   assign busy_o = (state_r != ST_IDLE);
endmodule

// File: rtl/div_restore_sm_chk.sv
module div_restore_sm_chk #(
   parameter int N = 8
) (
   input logic         clk,
   input logic         rst_n,
   input logic         start_i,
   input logic         busy_o,
   input logic         done_o,
   input logic [N+1:0] quo_o,
   input logic         quo_sign_o,
   input logic [N-1:0] rem_o,
   input logic         ovf_o,
   input logic         dz_o,
   input logic         zero_o
);
   p_done_pulse_r2: assert property (@(posedge clk) disable iff (!rst_n)
      done_o |=> !done_o);

   p_done_idle_r2: assert property (@(posedge clk) disable iff (!rst_n)
      done_o |-> !busy_o);

   p_start_busy_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (start_i && !busy_o) |=> busy_o);

   p_flags_excl_r3: assert property (@(posedge clk) disable iff (!rst_n)
      $countones({ovf_o, dz_o, zero_o}) <= 1);

   p_no_overflow_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (done_o && ovf_o) |-> (quo_o == '0 && rem_o == '0));

   p_dz_clear_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (done_o && dz_o) |-> (quo_o == '0 && rem_o == '0));

   p_zero_quo_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (done_o && zero_o) |-> (quo_o == '0));

   p_pos_sign_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (done_o && !quo_sign_o) |-> !quo_o[N+1]);

   p_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
      !busy_o |=> ($stable(quo_o) && $stable(rem_o) && $stable(quo_sign_o)
                   && $stable(ovf_o) && $stable(dz_o) && $stable(zero_o)));
endmodule

bind div_restore_sm div_restore_sm_chk #(.N(N)) u_chk (
   .clk (clk), .rst_n (rst_n), .start_i (start_i), .busy_o (busy_o),
   .done_o (done_o), .quo_o (quo_o), .quo_sign_o (quo_sign_o),
   .rem_o (rem_o), .ovf_o (ovf_o), .dz_o (dz_o), .zero_o (zero_o)
);

// File: tb/tb_div_restore_sm.sv
module tb_div_restore_sm;
   localparam int N  = 8;
   localparam int QW = N + 2;

   logic           clk = 1'b0;
   logic           rst_n = 1'b0;
   logic           start_i = 1'b0;
   logic           dvd_sign_i = 1'b0;
   logic [2*N-1:0] dvd_mag_i = '0;
   logic           dvs_sign_i = 1'b0;
   logic [N-1:0]   dvs_mag_i = '0;
   logic           busy_o, done_o, quo_sign_o, ovf_o, dz_o, zero_o;
   logic [QW-1:0]  quo_o;
   logic [N-1:0]   rem_o;

   int n_chk = 0;
   int n_bad = 0;

   always #4 clk = ~clk;

   div_restore_sm #(.N(N), .ROUND_EN(1'b1)) dut (
      .clk (clk), .rst_n (rst_n), .start_i (start_i),
      .dvd_sign_i (dvd_sign_i), .dvd_mag_i (dvd_mag_i),
      .dvs_sign_i (dvs_sign_i), .dvs_mag_i (dvs_mag_i),
      .busy_o (busy_o), .done_o (done_o), .quo_o (quo_o),
      .quo_sign_o (quo_sign_o), .rem_o (rem_o),
      .ovf_o (ovf_o), .dz_o (dz_o), .zero_o (zero_o)
   );

   task automatic check(input string req, input string what,
                        input longint act, input longint exp);
      n_chk++;
      if (act != exp) begin
         n_bad++;
         $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
      end
   endtask

   // Expected results from the requirements
   task automatic run_div(input logic ds, input logic [2*N-1:0] dm,
                          input logic vs, input logic [N-1:0] vm,
                          input bit spam_start);
      logic [N-1:0]  hi, lo;
      logic [QW-1:0] emag, equo;
      logic [N-1:0]  erem;
      logic          eovf, edz, ezero;
      int            elat, cyc;
      hi = dm[2*N-1:N];
      lo = dm[N-1:0];
      eovf = 0; edz = 0; ezero = 0; emag = '0; erem = '0;
      if (vm == 0) begin
         edz = 1; elat = 1;
      end else if (hi >= vm) begin
         eovf = 1; elat = 1;
      end else if (hi == 0 && lo < vm) begin
         ezero = 1; erem = lo; elat = 1;
      end else begin
         emag = QW'(dm / vm);
         erem = N'(dm % vm);
         if (2 * int'(erem) >= int'(vm)) emag = emag + 1;
         elat = N + 2;
      end
      equo = (ds ^ vs) ? QW'(-emag) : emag;

      @(negedge clk);
      start_i = 1'b1; dvd_sign_i = ds; dvd_mag_i = dm;
      dvs_sign_i = vs; dvs_mag_i = vm;
      cyc = 0;
      @(negedge clk);
      cyc = 1;
      check("R2", "busy after start", busy_o, 1);
      if (spam_start) begin
         dvd_mag_i = ~dm; dvs_mag_i = vm ^ N'(1); dvd_sign_i = ~ds;
      end else begin
         start_i = 1'b0;
      end
      while (!done_o && cyc < 4 * N) begin
         if (cyc > 1) check("R2", "busy while running", busy_o, 1);
         @(negedge clk);
         cyc++;
      end
      start_i = 1'b0;
      if (eovf)       check("R3", "latency", cyc - 1, elat);
      else if (edz)   check("R4", "latency", cyc - 1, elat);
      else if (ezero) check("R5", "latency", cyc - 1, elat);
      else            check("R6", "latency", cyc - 1, elat);
      check("R2", "busy low at done", busy_o, 0);
      check("R3", "ovf flag", ovf_o, eovf);
      check("R4", "dz flag", dz_o, edz);
      check("R5", "zero flag", zero_o, ezero);
      check("R6", "remainder", rem_o, erem);
      check("R7", "quotient sign", quo_sign_o, ds ^ vs);
      check(edz || eovf || ezero ? "R3" : "R8", "quotient", quo_o, equo);
      check("R9", "quotient msb", quo_o[QW-1], equo[QW-1]);
      @(negedge clk);
      check("R2", "done one cycle", done_o, 0);
      repeat (2) @(negedge clk);
      check("R10", "held quotient", quo_o, equo);
      check("R10", "held remainder", rem_o, erem);
   endtask

   initial begin : watchdog
      repeat (150000) @(posedge clk);
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
   end

   initial begin : stim
      logic [N-1:0] vm, hi, lo;
      int           mode;
      void'($urandom(32'd1234));
      repeat (3) @(negedge clk);
      // R1 reset state
      check("R1", "busy", busy_o, 0);
      check("R1", "done", done_o, 0);
      check("R1", "quo", quo_o, 0);
      check("R1", "rem", rem_o, 0);
      check("R1", "flags", {ovf_o, dz_o, zero_o, quo_sign_o}, 0);
      rst_n = 1'b1;
      @(negedge clk);
      check("R1", "idle after reset", busy_o, 0);

      // Directed corner cases
      run_div(1'b0, 16'd100, 1'b0, 8'd7, 0);      // R6/R8: 14 r2, no round
      run_div(1'b1, 16'd100, 1'b0, 8'd8, 0);      // R9: 12 r4 rounds to -13
      run_div(1'b1, 16'd99, 1'b1, 8'd10, 0);      // R7: signs cancel
      run_div(1'b0, 16'h1234, 1'b1, 8'd0, 0);     // R4 divide by zero
      run_div(1'b1, 16'h0A00, 1'b0, 8'd10, 0);    // R3 hi == divisor
      run_div(1'b0, 16'hFFFF, 1'b0, 8'd3, 0);     // R3 hi > divisor
      run_div(1'b1, 16'd5, 1'b0, 8'd9, 0);        // R5 trivially zero
      run_div(1'b0, 16'h00FF, 1'b0, 8'd1, 0);     // R6 full low half
      run_div(1'b0, 16'hFEFF, 1'b1, 8'hFF, 0);    // R8 max quotient
      run_div(1'b0, 16'd1000, 1'b0, 8'd9, 1);     // R2 start ignored while busy

      for (int i = 0; i < 200; i++) begin
         mode = int'($urandom % 8);
         vm = N'($urandom);
         lo = N'($urandom);
         if (mode == 0) vm = '0;
         if (vm == 0 && mode != 0) vm = N'(1);
         if (mode == 1) hi = vm + N'($urandom % (256 - int'(vm)));
         else if (mode == 2) begin hi = '0; lo = (vm == 0) ? lo : N'($urandom % vm); end
         else hi = (vm == 0) ? N'($urandom) : N'($urandom % vm);
         run_div(1'($urandom), {hi, lo}, 1'($urandom), vm, (mode == 3));
      end

      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
   end
endmodule